// File: doc/BRIEF.md
# Memory System Chip-Select Decoder

This block sits between a small processor and its local memory. The memory is four 128-byte RAM chips and one 512-byte ROM, all on a 10-bit address bus. From the address and the read and write strobes, the block works out which device takes part in the access. It gives each device a chip-select pair, one select active high and one active low. It trims the address down to the local offset that each device sees. An 8-bit bidirectional data bus is driven through a single tri-state enable.

The RAM and ROM arrays are modelled behaviourally inside the block, so a complete access path can be checked. RAM writes take effect on the rising clock edge. Reads are combinational: the selected device drives the shared bus in the same cycle as the read strobe. The ROM holds a fixed pattern computed from its address. The ROM cannot be written.

Top module: `msd_memsys`

## Requirements
- R1: Address bit 9 equal to 0 marks a RAM access. Address bits 8:7 then pick the RAM chip, values 0 to 3 selecting chip 0 to 3, which occupy 0x000-0x07F, 0x080-0x0FF, 0x100-0x17F and 0x180-0x1FF. The active-high select of exactly that chip is 1 during a valid access. All RAM active-high selects are 0 for addresses 0x200-0x3FF and when no valid access is in progress.
- R2: The active-low select of every RAM chip equals address bit 9. The ROM active-low select equals the inverse of address bit 9. The ROM active-high select is 1 only during a valid access with address bit 9 equal to 1.
- R3: The local address of each RAM chip is address bits 6:0. The local address of the ROM is address bits 8:0.
- R4: When write is 1 and read is 0 with a RAM address, the value on the data bus is stored at the clock edge into the selected chip at its local address. A later read of that address returns the value.
- R5: When read is 1 and write is 0, the bus enable is 1 and the data bus carries the selected device's byte in the same cycle.
- R6: The ROM byte at local offset a is a[7:0] XOR 0xA5 when a[8] is 1, and a[7:0] XOR 0x5A otherwise. A write to any address in 0x200-0x3FF leaves all ROM and RAM contents unchanged.
- R7: When no read is active, the bus enable is 0 and the block leaves the data bus at high impedance. At most one device drives the bus in any cycle.
- R8: Read and write both at 1 sets the error output to 1. It clears all active-high selects and the bus enable, and no RAM location changes.
- R9: After reset every RAM location reads 0.
- R10: A write changes only the selected chip: the same local address in the other RAM chips keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; RAM writes on rising edge |
| rst_n | input | 1 | Active-low reset, clears RAM contents |
| addr_i | input | 10 | Processor address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| data_io | inout | 8 | Bidirectional data bus |
| ram_cs_o | output | 4 | Active-high select per RAM chip |
| ram_cs_n_o | output | 4 | Active-low select per RAM chip |
| rom_cs_o | output | 1 | ROM active-high select |
| rom_cs_n_o | output | 1 | ROM active-low select |
| ram_addr_o | output | 7 | Local address for RAM chips |
| rom_addr_o | output | 9 | Local address for the ROM |
| bus_oe_o | output | 1 | Tri-state enable of the data bus |
| err_o | output | 1 | Read and write requested together |

## Verification
Some properties are checked by assertions on every cycle. The RAM selects are never more than one-hot, and RAM and ROM selects never overlap. No more than one device drives the bus. The bus enable appears only for a clean read, and an error cycle selects nothing. A RAM chip whose write is not enabled keeps all its contents, and an enabled write lands at the addressed location. Other behaviour is shown only by the bench's scenarios against its own model of the memory: the exact region boundaries, the ROM pattern, the zero contents after reset, the isolation between chips at equal local offsets, and the bus floating to high impedance.

// File: rtl/msd_pkg.sv
package msd_pkg;
    parameter int ADDR_W    = 10;
    parameter int DATA_W    = 8;
    parameter int RAM_CHIPS = 4;
    parameter int RAM_AW    = 7;
    parameter int ROM_AW    = 9;

    localparam int SEL_W     = $clog2(RAM_CHIPS);
    localparam int REGION_B  = ADDR_W - 1;
    localparam int RAM_DEPTH = 1 << RAM_AW;
    localparam int DEVICES   = RAM_CHIPS + 1;

    typedef struct packed {
        logic [RAM_CHIPS-1:0] ram_cs;
        logic [RAM_CHIPS-1:0] ram_cs_n;
        logic                 rom_cs;
        logic                 rom_cs_n;
        logic                 do_read;
        logic                 do_write;
        logic                 err;
    } decode_t;

    function automatic logic [DATA_W-1:0] rom_pattern(input logic [ROM_AW-1:0] a);
        logic [DATA_W-1:0] key;
        key = a[ROM_AW-1] ? 8'hA5 : 8'h5A;
        return a[DATA_W-1:0] ^ key;
    endfunction
endpackage

// File: rtl/msd_decode.sv
module msd_decode
    import msd_pkg::*;
(
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output decode_t           dec_o
);
    logic              is_rom;
    logic [SEL_W-1:0]  chip;
    logic              access;

    always_comb begin
        is_rom        = addr_i[REGION_B];
        chip          = addr_i[RAM_AW +: SEL_W];
        access        = rd_i ^ wr_i;
        dec_o         = '0;
        dec_o.err     = rd_i & wr_i;
        dec_o.do_read = rd_i & ~wr_i;
        dec_o.do_write= wr_i & ~rd_i;
        dec_o.rom_cs  = access & is_rom;
        dec_o.rom_cs_n= ~is_rom;
        for (int k = 0; k < RAM_CHIPS; k++) begin
            dec_o.ram_cs[k]   = access & ~is_rom & (chip == SEL_W'(k));
            dec_o.ram_cs_n[k] = is_rom;
        end
    end
endmodule

// File: rtl/msd_ram_chip.sv
module msd_ram_chip
    import msd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              cs_n_i,
    input  logic              we_i,
    input  logic              re_i,
    input  logic [RAM_AW-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    typedef struct packed {
        logic [RAM_DEPTH-1:0][DATA_W-1:0] mem;
    } ram_state_t;

    ram_state_t state_d, state_q;
    logic       sel;
    logic       wr_en;

    always_comb begin
        sel     = cs_i & ~cs_n_i;
        wr_en   = sel & we_i;
        state_d = state_q;
        if (wr_en) begin
            state_d.mem[addr_i] = wdata_i;
        end
        rdata_o = state_q.mem[addr_i];
        drive_o = sel & re_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assert_hold_unselected_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_i && !cs_n_i && we_i) |=> state_q == $past(state_q));

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && !cs_n_i && we_i) |=> state_q.mem[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/msd_rom.sv
module msd_rom
    import msd_pkg::*;
(
    input  logic              cs_i,
    input  logic              cs_n_i,
    input  logic              re_i,
    input  logic [ROM_AW-1:0] addr_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              drive_o
);
    always_comb begin
        rdata_o = rom_pattern(addr_i);
        drive_o = cs_i & ~cs_n_i & re_i;
    end
endmodule

// File: rtl/msd_memsys.sv
module msd_memsys
    import msd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 rd_i,
    input  logic                 wr_i,
    inout  wire  [DATA_W-1:0]    data_io,
    output logic [RAM_CHIPS-1:0] ram_cs_o,
    output logic [RAM_CHIPS-1:0] ram_cs_n_o,
    output logic                 rom_cs_o,
    output logic                 rom_cs_n_o,
    output logic [RAM_AW-1:0]    ram_addr_o,
    output logic [ROM_AW-1:0]    rom_addr_o,
    output logic                 bus_oe_o,
    output logic                 err_o
);
    decode_t                         dec;
    logic [DEVICES-1:0]              drive;
    logic [DEVICES-1:0][DATA_W-1:0]  dev_data;
    logic [DATA_W-1:0]               bus_out;

    msd_decode u_dec (
        .addr_i (addr_i),
        .rd_i   (rd_i),
        .wr_i   (wr_i),
        .dec_o  (dec)
    );

    for (genvar k = 0; k < RAM_CHIPS; k++) begin : g_ram
        msd_ram_chip u_ram (
            .clk     (clk),
            .rst_n   (rst_n),
            .cs_i    (dec.ram_cs[k]),
            .cs_n_i  (dec.ram_cs_n[k]),
            .we_i    (dec.do_write),
            .re_i    (dec.do_read),
            .addr_i  (addr_i[RAM_AW-1:0]),
            .wdata_i (data_io),
            .rdata_o (dev_data[k]),
            .drive_o (drive[k])
        );
    end

    msd_rom u_rom (
        .cs_i    (dec.rom_cs),
        .cs_n_i  (dec.rom_cs_n),
        .re_i    (dec.do_read),
        .addr_i  (addr_i[ROM_AW-1:0]),
        .rdata_o (dev_data[RAM_CHIPS]),
        .drive_o (drive[RAM_CHIPS])
    );

    always_comb begin
        bus_out = '0;
        for (int d = 0; d < DEVICES; d++) begin
            if (drive[d]) bus_out = bus_out | dev_data[d];
        end
        bus_oe_o   = |drive;
        ram_cs_o   = dec.ram_cs;
        ram_cs_n_o = dec.ram_cs_n;
        rom_cs_o   = dec.rom_cs;
        rom_cs_n_o = dec.rom_cs_n;
        ram_addr_o = addr_i[RAM_AW-1:0];
        rom_addr_o = addr_i[ROM_AW-1:0];
        err_o      = dec.err;
    end

    assign data_io = bus_oe_o ? bus_out : {DATA_W{1'bz}};

    assert_ram_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ram_cs_o));

    assert_region_split_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs_o |-> (ram_cs_o == '0));

    assert_single_driver_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(drive) <= 1);

    assert_oe_needs_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe_o |-> (rd_i && !wr_i));

    assert_conflict_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!bus_oe_o && ram_cs_o == '0 && !rom_cs_o));
endmodule

// File: tb/sim_msd_memsys.sv
`timescale 1ns/1ps
module sim_msd_memsys;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] addr = '0;
    logic       rd = 1'b0, wr = 1'b0;
    logic       tb_drv = 1'b0;
    logic [7:0] tb_data = '0;
    wire  [7:0] data_io;
    logic [3:0] ram_cs, ram_cs_n;
    logic       rom_cs, rom_cs_n, bus_oe, err;
    logic [6:0] ram_addr;
    logic [8:0] rom_addr;

    int total = 0, bad = 0;
    logic [7:0] ref_ram [512];

    typedef struct { logic [7:0] val; string req; logic [9:0] a; } item_t;
    item_t q[$];

    always #2 clk = ~clk;
    assign data_io = tb_drv ? tb_data : 8'bz;

    msd_memsys u0 (
        .clk(clk), .rst_n(rst_n), .addr_i(addr), .rd_i(rd), .wr_i(wr),
        .data_io(data_io), .ram_cs_o(ram_cs), .ram_cs_n_o(ram_cs_n),
        .rom_cs_o(rom_cs), .rom_cs_n_o(rom_cs_n), .ram_addr_o(ram_addr),
        .rom_addr_o(rom_addr), .bus_oe_o(bus_oe), .err_o(err)
    );

    function automatic logic [7:0] rom_exp(input logic [8:0] a);
        return a[7:0] ^ (a[8] ? 8'hA5 : 8'h5A);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h (addr=%h)", req, act, exp, addr);
        end
    endtask

    task automatic check_decode(input logic r, input logic w);
        logic ok;
        logic [3:0] exp_cs;
        ok = r ^ w;
        exp_cs = '0;
        if (ok && !addr[9]) exp_cs[addr[8:7]] = 1'b1;
        check("R1", {28'b0, ram_cs}, {28'b0, exp_cs});
        check("R2", {28'b0, ram_cs_n}, {28'b0, {4{addr[9]}}});
        check("R2", {30'b0, rom_cs, rom_cs_n}, {30'b0, ok & addr[9], ~addr[9]});
        check("R3", {25'b0, ram_addr}, {25'b0, addr[6:0]});
        check("R3", {23'b0, rom_addr}, {23'b0, addr[8:0]});
    endtask

    task automatic do_write(input logic [9:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        addr = a; wr = 1'b1; rd = 1'b0; tb_drv = 1'b1; tb_data = d;
        if (!a[9]) ref_ram[a[8:0]] = d;
        #0.5 check_decode(1'b0, 1'b1);
        check("R5", {31'b0, bus_oe}, 32'd0);
    endtask

    task automatic do_read(input logic [9:0] a, input string req);
        item_t it;
        @(posedge clk); #1;
        addr = a; wr = 1'b0; tb_drv = 1'b0; rd = 1'b1;
        it.val = a[9] ? rom_exp(a[8:0]) : ref_ram[a[8:0]];
        it.req = req;
        it.a = a;
        q.push_back(it);
        #0.5 check_decode(1'b1, 1'b0);
    endtask

    task automatic do_idle();
        @(posedge clk); #1;
        rd = 1'b0; wr = 1'b0; tb_drv = 1'b0;
        #0.5;
        check("R7", {31'b0, bus_oe}, 32'd0);
        check("R7", {24'b0, data_io}, {24'b0, 8'bzzzzzzzz});
    endtask

    always @(negedge clk) begin
        if (rd && !wr && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            check("R5", {31'b0, bus_oe}, 32'd1);
            check(it.req, {24'b0, data_io}, {24'b0, it.val});
        end
    end

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 512; i++) ref_ram[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        do_idle();
        // R9: contents zero after reset, one probe per chip
        for (int k = 0; k < 4; k++) do_read(10'(k * 128 + 7), "R9");
        // R4 R1: fill each chip, boundaries of every region
        for (int k = 0; k < 4; k++) begin
            do_write(10'(k * 128),       8'(8'h10 + k));
            do_write(10'(k * 128 + 127), 8'(8'hE0 + k));
        end
        for (int k = 0; k < 4; k++) begin
            do_read(10'(k * 128),       "R4");
            do_read(10'(k * 128 + 127), "R1");
        end
        // R10: same offset in another chip is untouched
        do_write(10'h005, 8'h3C);
        for (int k = 0; k < 4; k++) do_read(10'(k * 128 + 5), "R10");
        // R6: ROM pattern, then a write into the ROM region
        do_read(10'h200, "R6");
        do_read(10'h3FF, "R6");
        do_read(10'h2FF, "R6");
        do_read(10'h300, "R6");
        do_write(10'h250, 8'h00);
        do_write(10'h3FF, 8'hFF);
        do_read(10'h250, "R6");
        do_read(10'h3FF, "R6");
        do_read(10'h07F, "R6");
        // R8: read and write together
        do_write(10'h090, 8'h77);
        @(posedge clk); #1;
        addr = 10'h090; rd = 1'b1; wr = 1'b1; tb_drv = 1'b1; tb_data = 8'h11;
        #0.5;
        check("R8", {31'b0, err}, 32'd1);
        check("R8", {28'b0, ram_cs}, 32'd0);
        check("R8", {31'b0, bus_oe}, 32'd0);
        do_idle();
        check("R8", {31'b0, err}, 32'd0);
        do_read(10'h090, "R8");
        // R4: varied pattern across RAM
        for (int i = 0; i < 32; i++) do_write(10'(i * 13 + 3), 8'(i * 37 + 1));
        for (int i = 0; i < 32; i++) do_read(10'(i * 13 + 3), "R4");
        do_idle();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule